// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Two-Way Data Cache

This block is a read-only data cache for a processor that translates addresses through a TLB. The set index and the block offset are taken only from the untranslated page-offset bits of the virtual address. The set read can therefore start while the TLB is still translating the page number. The TLB sits outside the block and is modelled as an input: in the cycle after a request is accepted, the TLB reports a hit flag and a physical page number. The block compares that page number against the tags of both ways in the selected set.

The cache has 256 sets of two ways, with 16-byte lines and a 30-bit physical address. A hit needs a TLB hit, a valid line and an equal tag. When the TLB hits but the tag does not match, the block fetches the whole line from memory in one transaction. It writes the line into the least-recently-used way of the set and returns the requested word. When the TLB misses, the block waits with its ready output low and issues no memory traffic. It resumes when the TLB reports a hit. A synchronous reset or an invalidate pulse clears every valid bit.

Top module: `vipt_cache`

## Requirements
- R1: After a synchronous reset, `cpu_ready` is 1, and `rsp_valid` and `mem_req` are 0. The first read of any address afterwards is a miss.
- R2: A request is accepted at a rising edge where `cpu_req` and `cpu_ready` are both 1. On a hit, `rsp_valid` is 1 for exactly one cycle, beginning after the second rising edge counted from acceptance. `rsp_data` carries the selected word.
- R3: A read hits only when the TLB hits, the line is valid, and the stored 18-bit tag equals `tlb_ppn`. A different page number with the same page offset misses.
- R4: While `tlb_hit` is 0 during a lookup, `cpu_ready` stays 0 and `mem_req` stays 0, and no response is given. The lookup completes once `tlb_hit` is 1.
- R5: On a miss with a TLB hit, `mem_req` rises with `mem_addr = {tlb_ppn, vaddr[11:4], 4'b0000}`, and it stays high and stable until `mem_valid`. After the edge that samples `mem_valid`, `rsp_valid` returns the requested word from `mem_data`, and later reads of that line hit.
- R6: Each set keeps one bit that names the way to evict, and reset sets it to 0. A hit or a fill of way w sets it to the other way. A fill always replaces the named way.
- R7: A one-cycle `inv` pulse clears all valid bits, so every line that hit before the pulse misses afterwards.
- R8: The word is selected by `vaddr[3:2]`, and word i of a line is `mem_data[32*i+31:32*i]`. `vaddr[31:12]` has no effect on the cache, so two virtual pages that map to one physical page share lines.
- R9: Only one request is in flight. `cpu_ready` is 0 from the edge after acceptance until the response cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv | input | 1 | Invalidate pulse: clears all valid bits |
| cpu_req | input | 1 | Read request |
| cpu_vaddr | input | 32 | Virtual byte address of the read |
| cpu_ready | output | 1 | Cache can accept a request |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 32 | Read data word |
| tlb_hit | input | 1 | TLB translation valid in the lookup cycle |
| tlb_ppn | input | 18 | Physical page number from the TLB |
| mem_req | output | 1 | Line fetch request, held until `mem_valid` |
| mem_addr | output | 30 | Line-aligned physical fetch address |
| mem_valid | input | 1 | Fetched line present on `mem_data` |
| mem_data | input | 128 | Fetched 16-byte line |

## Verification
On every cycle, the embedded assertions check the following:
- the single-cycle response pulse;
- the busy state that follows acceptance;
- that a TLB miss never starts a fetch or a response;
- that a fetch request stays stable until memory answers;
- that an invalidate leaves no valid bit set;
- that each touch turns the replacement bit away from the touched way.

Only the bench scenarios can show that data comes back correct through the hit and fill paths. They also show that tags from different physical pages are told apart and that the replacement order evicts the right line across a sequence of hits and fills. Finally, they show that lines which hit before an invalidate or a reset miss after it.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;
  localparam int unsigned WAYS = 2;
  localparam int unsigned WAY_IDX_W = 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_REFILL = 2'd2
  } cache_state_e;
endpackage

// File: rtl/vipt_sdp_ram.sv
module vipt_sdp_ram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // one write port, one registered read port: maps onto a simple dual-port block RAM
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/vipt_word_pick.sv
module vipt_word_pick #(
  parameter int unsigned LINE_W = 128,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NWORDS = LINE_W / WORD_W,
  localparam int unsigned SEL_W = $clog2(NWORDS)
) (
  input  logic [LINE_W-1:0] line,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = line[sel*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match
  import vipt_cache_pkg::*;
#(
  parameter int unsigned TAG_W = 18
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [TAG_W-1:0]           ppn,
  input  logic                       tlb_hit,
  output logic [WAYS-1:0]            match,
  output logic                       any_hit,
  output logic [WAY_IDX_W-1:0]       hit_idx
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    // a translated page that is absent can never qualify a way (R3)
    assign match[w] = tlb_hit && way_valid[w] && (way_tag[w] == ppn);
  end

  assign any_hit = |match;

  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_idx = WAY_IDX_W'(w);
    end
  end
endmodule

// File: rtl/vipt_repl_state.sv
module vipt_repl_state
  import vipt_cache_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned SETS = 1 << IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inv,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [WAYS-1:0]      rd_valid,
  output logic [WAY_IDX_W-1:0] rd_victim,
  input  logic                 touch,
  input  logic                 fill,
  input  logic [IDX_W-1:0]     touch_idx,
  input  logic [WAY_IDX_W-1:0] touch_way
);
  logic [WAYS-1:0][SETS-1:0] valid_q;
  logic [SETS-1:0]           lru_q;

  always_ff @(posedge clk) begin
    if (rst || inv) begin
      valid_q <= '0;
    end else if (fill) begin
      valid_q[touch_way][touch_idx] <= 1'b1;
    end
  end

  // bit names the way to evict next; a touch turns it to the other way
  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q <= '0;
    end else if (touch) begin
      lru_q[touch_idx] <= ~touch_way;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rdv
    assign rd_valid[w] = valid_q[w][rd_idx];
  end
  assign rd_victim = lru_q[rd_idx];

  a_r7_inv_clears_all: assert property (@(posedge clk) disable iff (rst)
    inv |=> (valid_q == '0));

  a_r6_lru_turns_away: assert property (@(posedge clk) disable iff (rst)
    touch |=> (lru_q[$past(touch_idx)] != $past(touch_way)));

  a_r5_fill_marks_valid: assert property (@(posedge clk) disable iff (rst)
    (fill && !inv) |=> valid_q[$past(touch_way)][$past(touch_idx)]);
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_cache_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PA_W       = 30,
  parameter int unsigned PAGE_W     = 12,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned WORD_W     = 32,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W  = PAGE_W - OFF_W,
  localparam int unsigned TAG_W  = PA_W - PAGE_W,
  localparam int unsigned LINE_W = LINE_BYTES * 8,
  localparam int unsigned BYTE_W = $clog2(WORD_W / 8),
  localparam int unsigned SEL_W  = OFF_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv,
  input  logic              cpu_req,
  input  logic [VA_W-1:0]   cpu_vaddr,
  output logic              cpu_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  input  logic              tlb_hit,
  input  logic [TAG_W-1:0]  tlb_ppn,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_valid,
  input  logic [LINE_W-1:0] mem_data
);
  cache_state_e         state_q;
  logic                 ready_q;
  logic                 rsp_valid_q;
  logic [WORD_W-1:0]    rsp_data_q;
  logic                 mem_req_q;
  logic [PA_W-1:0]      mem_addr_q;
  logic [IDX_W-1:0]     idx_q;
  logic [SEL_W-1:0]     sel_q;
  logic [WAY_IDX_W-1:0] victim_q;
  logic [TAG_W-1:0]     ppn_q;

  logic                 accept;
  logic                 fill_we;
  logic [IDX_W-1:0]     req_idx;
  logic [SEL_W-1:0]     req_sel;

  logic [WAYS-1:0][TAG_W-1:0]  way_tag;
  logic [WAYS-1:0][LINE_W-1:0] way_line;
  logic [WAYS-1:0][WORD_W-1:0] way_word;
  logic [WAYS-1:0]             way_valid;
  logic [WAYS-1:0]             way_match;
  logic                        any_hit;
  logic [WAY_IDX_W-1:0]        hit_idx;
  logic [WAY_IDX_W-1:0]        lru_victim;
  logic [WORD_W-1:0]           hit_word;
  logic [WORD_W-1:0]           fill_word;
  logic                        lookup_hit;
  logic                        touch;
  logic [WAY_IDX_W-1:0]        touch_way;
  logic                        unused_va_bits;

  // page number and byte-in-word bits never reach the cache arrays
  assign unused_va_bits = ^{cpu_vaddr[VA_W-1:PAGE_W], cpu_vaddr[BYTE_W-1:0]};

  assign req_idx = cpu_vaddr[PAGE_W-1:OFF_W];
  assign req_sel = cpu_vaddr[OFF_W-1:BYTE_W];
  assign accept  = (state_q == ST_IDLE) && cpu_req;
  assign fill_we = (state_q == ST_REFILL) && mem_valid;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic way_we;
    assign way_we = fill_we && (victim_q == WAY_IDX_W'(w));

    vipt_sdp_ram #(.DW(TAG_W), .AW(IDX_W)) u_tag_ram (
      .clk   (clk),
      .we    (way_we),
      .waddr (idx_q),
      .wdata (ppn_q),
      .re    (accept),
      .raddr (req_idx),
      .rdata (way_tag[w])
    );

    vipt_sdp_ram #(.DW(LINE_W), .AW(IDX_W)) u_data_ram (
      .clk   (clk),
      .we    (way_we),
      .waddr (idx_q),
      .wdata (mem_data),
      .re    (accept),
      .raddr (req_idx),
      .rdata (way_line[w])
    );

    vipt_word_pick #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_pick (
      .line (way_line[w]),
      .sel  (sel_q),
      .word (way_word[w])
    );
  end

  vipt_word_pick #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_fill_pick (
    .line (mem_data),
    .sel  (sel_q),
    .word (fill_word)
  );

  vipt_way_match #(.TAG_W(TAG_W)) u_match (
    .way_tag   (way_tag),
    .way_valid (way_valid),
    .ppn       (tlb_ppn),
    .tlb_hit   (tlb_hit),
    .match     (way_match),
    .any_hit   (any_hit),
    .hit_idx   (hit_idx)
  );

  always_comb begin
    hit_word = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_match[w]) hit_word = hit_word | way_word[w];
    end
  end

  assign lookup_hit = (state_q == ST_LOOKUP) && any_hit;
  assign touch      = lookup_hit || fill_we;
  assign touch_way  = fill_we ? victim_q : hit_idx;

  vipt_repl_state #(.IDX_W(IDX_W)) u_repl (
    .clk       (clk),
    .rst       (rst),
    .inv       (inv),
    .rd_idx    (idx_q),
    .rd_valid  (way_valid),
    .rd_victim (lru_victim),
    .touch     (touch),
    .fill      (fill_we),
    .touch_idx (idx_q),
    .touch_way (touch_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      ready_q     <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      mem_req_q   <= 1'b0;
      mem_addr_q  <= '0;
      idx_q       <= '0;
      sel_q       <= '0;
      victim_q    <= '0;
      ppn_q       <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cpu_req) begin
            idx_q   <= req_idx;
            sel_q   <= req_sel;
            ready_q <= 1'b0;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          // without a translation the lookup simply waits (R4)
          if (tlb_hit) begin
            if (any_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= hit_word;
              ready_q     <= 1'b1;
              state_q     <= ST_IDLE;
            end else begin
              mem_req_q  <= 1'b1;
              mem_addr_q <= {tlb_ppn, idx_q, {OFF_W{1'b0}}};
              victim_q   <= lru_victim;
              ppn_q      <= tlb_ppn;
              state_q    <= ST_REFILL;
            end
          end
        end
        ST_REFILL: begin
          if (mem_valid) begin
            mem_req_q   <= 1'b0;
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= fill_word;
            ready_q     <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = ready_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign mem_req   = mem_req_q;
  assign mem_addr  = mem_addr_q;

  a_r4_no_fetch_without_tlb: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_LOOKUP) && !tlb_hit) |=> (!mem_req && !rsp_valid && !cpu_ready));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready) |=> !cpu_ready);

  a_r5_fetch_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/vipt_cache_tb.sv
`timescale 1ns/1ps
module vipt_cache_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inv = 1'b0;
  logic         cpu_req = 1'b0;
  logic [31:0]  cpu_vaddr = '0;
  logic         cpu_ready;
  logic         rsp_valid;
  logic [31:0]  rsp_data;
  logic         tlb_hit = 1'b0;
  logic [17:0]  tlb_ppn = '0;
  logic         mem_req;
  logic [29:0]  mem_addr;
  logic         mem_valid = 1'b0;
  logic [127:0] mem_data = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  vipt_cache u_dut (
    .clk(clk), .rst(rst), .inv(inv),
    .cpu_req(cpu_req), .cpu_vaddr(cpu_vaddr), .cpu_ready(cpu_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [17:0] ppn;
    logic        hit;
  } vec_t;

  // walked in order from a fresh reset; set 0x23 carries the replacement story
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1234, 18'h00011, 1'b0},  // R5 first fill, way 0
    '{32'h0000_1238, 18'h00011, 1'b1},  // R2 hit, word 2
    '{32'h7777_523C, 18'h00011, 1'b1},  // R8 other virtual page, same frame
    '{32'h0000_1234, 18'h00022, 1'b0},  // R3 tag mismatch, fills way 1
    '{32'h0000_1234, 18'h00011, 1'b1},  // R6 hit way 0, way 1 next victim
    '{32'h0000_1230, 18'h00033, 1'b0},  // R6 evicts page 0x22
    '{32'h0000_1234, 18'h00011, 1'b1},  // R6 way 0 survived
    '{32'h0000_1234, 18'h00022, 1'b0},  // R6 evicted line misses
    '{32'h0000_0FF0, 18'h3FFFF, 1'b0},  // R5 last set, top page
    '{32'h0000_0FFC, 18'h3FFFF, 1'b1},  // R8 word 3
    '{32'h0000_0000, 18'h00000, 1'b0},  // R5 set 0, page 0
    '{32'h0000_0004, 18'h00000, 1'b1}   // R2 word 1
  };

  function automatic logic [31:0] word_of(input logic [25:0] line_addr, input logic [1:0] i);
    return {line_addr, i, 4'b0101};
  endfunction

  function automatic logic [127:0] line_of(input logic [25:0] line_addr);
    logic [127:0] l;
    for (int i = 0; i < 4; i++) l[32*i +: 32] = word_of(line_addr, 2'(i));
    return l;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] va, input logic [17:0] ppn, input int stall,
                         input bit exp_hit, input string rq);
    bit got_mem = 1'b0;
    bit got_rsp = 1'b0;
    logic [25:0] la;
    la = {ppn, va[11:4]};
    @(negedge clk);
    cpu_req = 1'b1;
    cpu_vaddr = va;
    tlb_hit = 1'b0;
    for (int i = 0; i < 20 && !cpu_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    tlb_ppn = ppn;
    tlb_hit = (stall == 0);
    check(!cpu_ready, {rq, "/R9"}, "ready low after accept", 64'(cpu_ready), 64'd0);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(!cpu_ready && !mem_req && !rsp_valid, {rq, "/R4"}, "stall during TLB miss",
            64'({cpu_ready, mem_req, rsp_valid}), 64'd0);
    end
    tlb_hit = 1'b1;
    for (int i = 0; i < 20 && !got_rsp; i++) begin
      @(negedge clk);
      mem_valid = 1'b0;
      if (rsp_valid) begin
        got_rsp = 1'b1;
        check(rsp_data == word_of(la, va[3:2]), rq, "read data",
              64'(rsp_data), 64'(word_of(la, va[3:2])));
        check(cpu_ready, {rq, "/R9"}, "ready back with response", 64'(cpu_ready), 64'd1);
      end else if (mem_req && !got_mem) begin
        got_mem = 1'b1;
        check(mem_addr == {la, 4'h0}, {rq, "/R5"}, "fetch address",
              64'(mem_addr), 64'({la, 4'h0}));
        mem_valid = 1'b1;
        mem_data = line_of(la);
      end
    end
    check(got_rsp, rq, "response seen", 64'(got_rsp), 64'd1);
    check(got_mem == !exp_hit, rq, "hit (1) or miss (0)", 64'(!got_mem), 64'(exp_hit));
    @(negedge clk);
    check(!rsp_valid, {rq, "/R2"}, "response lasts one cycle", 64'(rsp_valid), 64'd0);
    tlb_hit = 1'b0;
    mem_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(cpu_ready && !rsp_valid && !mem_req, "R1", "outputs after reset",
          64'({cpu_ready, rsp_valid, mem_req}), 64'b100);

    for (int v = 0; v < NV; v++) begin
      do_read(VECS[v].va, VECS[v].ppn, 0, VECS[v].hit, $sformatf("R2/R3/R5/R6/R8 vec%0d", v));
    end

    // R4: TLB miss on a line that hits, then on a line that misses
    do_read(32'h0000_1234, 18'h00011, 3, 1'b1, "R4 stalled hit");
    do_read(32'h0000_1234, 18'h00044, 2, 1'b0, "R4 stalled miss");

    // R7: invalidate pulse drops every line
    do_read(32'h0000_0000, 18'h00000, 0, 1'b1, "R7 before invalidate");
    @(negedge clk); inv = 1'b1;
    @(negedge clk); inv = 1'b0;
    check(cpu_ready, "R7", "ready after invalidate", 64'(cpu_ready), 64'd1);
    do_read(32'h0000_0000, 18'h00000, 0, 1'b0, "R7 set 0 after invalidate");
    do_read(32'h0000_0FF0, 18'h3FFFF, 0, 1'b0, "R7 set 255 after invalidate");

    // R1: reset mid-run also empties the cache
    do_read(32'h0000_1234, 18'h00011, 0, 1'b0, "R1 refill before reset");
    do_read(32'h0000_1234, 18'h00011, 0, 1'b1, "R1 hit before reset");
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(cpu_ready && !rsp_valid && !mem_req, "R1", "outputs after second reset",
          64'({cpu_ready, rsp_valid, mem_req}), 64'b100);
    do_read(32'h0000_1234, 18'h00011, 0, 1'b0, "R1 miss after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule